// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This block keeps the running address and the remaining transfer count for one DMA channel. A load strobe sets the start address, the transfer count, the addressing mode and the transfer unit, which is either one byte or one 16-bit word. Each transfer-done strobe after that moves the address to the next element and lowers the count by one. When the count reaches zero the unit raises a terminal-count pulse for one cycle. It then stays idle until it is loaded again.

There are two addressing modes. Linear mode steps the full address by the unit size, with carries moving into the upper bits. Ring mode selects a ring of 2, 4, 8, 16 or 32 elements. Only a low field of the address cycles, and its width depends on both the ring length and the unit size. The bits above that field never change, so the address comes back to the start address after one full ring and then repeats. A ring start address whose low field is not zero is flagged and then aligned down. In word mode the address output always has bit 0 clear, because words move as aligned pairs of bytes.

Top module: `dma_ring_addr_gen`

## Requirements
- R1: After reset, `cur_addr`, `remaining`, `tc_pulse`, `align_err` and `word_mode` are all zero.
- R2: A cycle with `load` high updates the outputs on the next edge. `remaining` becomes `load_count`. `cur_addr` becomes `load_addr`, aligned down in ring mode. `tc_pulse` is low.
- R3: In linear mode (`ring_en`=0), each accepted advance adds 1 to the address for bytes (`unit16`=0) or 2 for words (`unit16`=1), across all address bits with full carry.
- R4: Byte ring mode: only the low log2(N) address bits step by one and wrap from all-ones to zero. The upper bits hold, so after N advances the address equals the start address.
- R5: Word ring mode: only the low log2(N)+1 address bits step by two and wrap to zero. The upper bits hold, so after N advances the address equals the start address.
- R6: `ring_sel` values 0, 1, 2, 3 and 4 select N = 2, 4, 8, 16 and 32. Values 5 to 7 select N = 32.
- R7: Each accepted advance lowers `remaining` by exactly one, for both unit sizes.
- R8: In word mode `word_mode` is 1 and bit 0 of `cur_addr` is 0. In byte mode `word_mode` is 0 and bit 0 of `cur_addr` follows the internal address, so odd byte addresses are allowed.
- R9: A ring load whose start address has any nonzero bit in the ring field sets `align_err`. Those bits are cleared before use. `align_err` holds until the next load, and a properly aligned load clears it.
- R10: The advance that takes `remaining` from 1 to 0 makes `tc_pulse` high for exactly one cycle. Advances while `remaining` is 0 change neither the address nor the count.
- R11: When `load` and `advance` are high in the same cycle, the load wins and the advance has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture start address, count, mode and unit |
| load_addr | input | ADDR_W | Start address |
| load_count | input | CNT_W | Number of transfers |
| ring_en | input | 1 | 1 selects ring mode, 0 selects linear mode |
| ring_sel | input | SEL_W | Ring length code (see R6) |
| unit16 | input | 1 | 1 selects 16-bit units, 0 selects bytes |
| advance | input | 1 | Transfer-done strobe |
| cur_addr | output | ADDR_W | Current transfer address |
| remaining | output | CNT_W | Transfers still to do |
| word_mode | output | 1 | High when the unit is a word, so the address is word-aligned |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| align_err | output | 1 | Ring start address was misaligned |

## Verification
The bench uses the default parameters: a 32-bit address, a 16-bit count and a 3-bit ring selector with a largest ring of 32. These values let the bench run a full 32-element ring in both unit sizes and see the wrap back to the start address. They also let it drive ring selector codes above 4 to check clamping. With the full address width, linear stepping can be checked as a carry moves up through byte and halfword boundaries. Start addresses with high bits set show that ring mode never touches the upper field.

// File: rtl/dma_ring_addr_gen.sv
module dma_ring_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 3,
  parameter int MAX_LOG  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_count,
  input  logic              ring_en,
  input  logic [SEL_W-1:0]  ring_sel,
  input  logic              unit16,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  remaining,
  output logic              word_mode,
  output logic              tc_pulse,
  output logic              align_err
);

  function automatic logic [ADDR_W-1:0] field_mask(input logic [SEL_W-1:0] sel,
                                                   input logic u16);
    int lg;
    lg = (int'(sel) >= MAX_LOG) ? MAX_LOG : int'(sel) + 1;
    if (u16) lg = lg + 1;
    return (ADDR_W'(1) << lg) - ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] addr_q, mask_q;
  logic [CNT_W-1:0]  rem_q;
  logic              ring_q, u16_q, tc_q, err_q;

  wire [ADDR_W-1:0] ld_mask  = field_mask(ring_sel, unit16);
  wire              step_ok  = advance && !load && (rem_q != '0);
  wire [ADDR_W-1:0] lin_next = addr_q + (u16_q ? ADDR_W'(2) : ADDR_W'(1));
  wire [ADDR_W-1:0] rng_next = (addr_q & ~mask_q) | (lin_next & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
      rem_q  <= '0;
      ring_q <= 1'b0;
      u16_q  <= 1'b0;
      tc_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (load) begin
      ring_q <= ring_en;
      u16_q  <= unit16;
      mask_q <= ring_en ? ld_mask : '0;
      addr_q <= ring_en ? (load_addr & ~ld_mask) : load_addr;
      err_q  <= ring_en && ((load_addr & ld_mask) != '0);
      rem_q  <= load_count;
      tc_q   <= 1'b0;
    end else begin
      tc_q <= step_ok && (rem_q == CNT_W'(1));
      if (step_ok) begin
        addr_q <= ring_q ? rng_next : lin_next;
        rem_q  <= rem_q - CNT_W'(1);
      end
    end
  end

  assign cur_addr  = u16_q ? {addr_q[ADDR_W-1:1], 1'b0} : addr_q;
  assign remaining = rem_q;
  assign word_mode = u16_q;
  assign tc_pulse  = tc_q;
  assign align_err = err_q;

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && remaining != '0) |=> remaining == $past(remaining) - CNT_W'(1));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && remaining == '0) |=> $stable(cur_addr) && remaining == '0);

  assert_tc_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);

  assert_upper_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_q && !load) |=> ((addr_q ^ $past(addr_q)) & ~mask_q) == '0);

  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> remaining == $past(load_count) && !tc_pulse);

  always_comb
    assert_word_even_R8: assert (!rst_n || !word_mode || cur_addr[0] == 1'b0);

endmodule

// File: tb/test_dma_ring_addr_gen.sv
`timescale 1ns/100ps
module test_dma_ring_addr_gen;
  logic        clk = 0, rst_n = 0;
  logic        load = 0, ring_en = 0, unit16 = 0, advance = 0;
  logic [31:0] load_addr = 0;
  logic [15:0] load_count = 0;
  logic [2:0]  ring_sel = 0;
  logic [31:0] cur_addr;
  logic [15:0] remaining;
  logic        word_mode, tc_pulse, align_err;

  dma_ring_addr_gen i_dma_ring_addr_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
    .load_count(load_count), .ring_en(ring_en), .ring_sel(ring_sel),
    .unit16(unit16), .advance(advance), .cur_addr(cur_addr),
    .remaining(remaining), .word_mode(word_mode), .tc_pulse(tc_pulse),
    .align_err(align_err));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] qa[$];
  logic [15:0] qr[$];
  logic [3:0]  qf[$];
  string       qt[$];

  logic [31:0] m_addr = 0, m_mask = 0;
  logic [15:0] m_rem = 0;
  bit m_ring = 0, m_u16 = 0, m_tc = 0, m_err = 0;

  function automatic logic [31:0] mk_mask(input logic [2:0] sel, input bit u16);
    int lg;
    lg = (sel > 4) ? 5 : int'(sel) + 1;
    return (32'd1 << (lg + (u16 ? 1 : 0))) - 32'd1;
  endfunction

  task automatic push(input string tag);
    qa.push_back(m_u16 ? {m_addr[31:1], 1'b0} : m_addr);
    qr.push_back(m_rem);
    qf.push_back({m_tc, m_err, m_u16, 1'b0});
    qt.push_back(tag);
  endtask

  task automatic drive(input bit ld, input bit adv, input logic [31:0] sa,
                       input logic [15:0] sc, input bit rg, input logic [2:0] sel,
                       input bit u16, input string tag);
    @(negedge clk);
    load = ld; advance = adv; load_addr = sa; load_count = sc;
    ring_en = rg; ring_sel = sel; unit16 = u16;
    if (ld) begin
      logic [31:0] mk;
      mk = mk_mask(sel, u16);
      m_ring = rg; m_u16 = u16; m_mask = rg ? mk : 0;
      m_err = rg && ((sa & mk) != 0);
      m_addr = rg ? (sa & ~mk) : sa;
      m_rem = sc; m_tc = 0;
    end else if (adv && m_rem != 0) begin
      logic [31:0] nx;
      nx = m_addr + (m_u16 ? 32'd2 : 32'd1);
      m_addr = m_ring ? ((m_addr & ~m_mask) | (nx & m_mask)) : nx;
      m_rem = m_rem - 1;
      m_tc = (m_rem == 0);
    end else m_tc = 0;
    push(tag);
  endtask

  task automatic do_load(input logic [31:0] sa, input logic [15:0] sc, input bit rg,
                         input logic [2:0] sel, input bit u16, input string tag);
    drive(1, 0, sa, sc, rg, sel, u16, tag);
  endtask

  task automatic do_adv(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 1, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_idle(input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && qa.size() > 0) begin
      logic [31:0] ea; logic [15:0] er; logic [3:0] ef; string et;
      ea = qa.pop_front(); er = qr.pop_front(); ef = qf.pop_front(); et = qt.pop_front();
      checks++;
      if (cur_addr !== ea || remaining !== er || tc_pulse !== ef[3] ||
          align_err !== ef[2] || word_mode !== ef[1]) begin
        fails++;
        $display("FAIL %s: addr=%h rem=%0d tc=%b err=%b word=%b expected addr=%h rem=%0d tc=%b err=%b word=%b",
                 et, cur_addr, remaining, tc_pulse, align_err, word_mode,
                 ea, er, ef[3], ef[2], ef[1]);
      end
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (cur_addr !== 0 || remaining !== 0 || tc_pulse !== 0 || align_err !== 0 || word_mode !== 0) begin
      fails++;
      $display("FAIL R1: addr=%h rem=%0d tc=%b err=%b word=%b expected all zero",
               cur_addr, remaining, tc_pulse, align_err, word_mode);
    end
    rst_n = 1;
    do_idle("R1 after reset");
    do_load(32'h0000_00FE, 16'd5, 0, 0, 0, "R2 linear byte load");
    do_adv(3, "R3 byte carry");
    do_load(32'h1000_FFFC, 16'd4, 0, 0, 1, "R2 linear word load");
    do_adv(3, "R3 word carry R7");
    do_load(32'h0000_0203, 16'd3, 0, 0, 1, "R8 odd start in word mode");
    do_adv(1, "R8 word output even");
    do_load(32'h0000_0203, 16'd3, 0, 0, 0, "R8 odd byte address");
    do_adv(1, "R8 byte odd to even");
    do_load(32'hABCD_1200, 16'd40, 1, 3'd4, 0, "R2 ring byte load");
    do_adv(34, "R4 byte ring 32");
    do_load(32'h2000_0040, 16'd40, 1, 3'd4, 1, "R2 ring word load");
    do_adv(34, "R5 word ring 32 R7");
    do_load(32'h0000_0010, 16'd6, 1, 3'd0, 0, "R6 ring of 2");
    do_adv(3, "R6 ring of 2 wrap");
    do_load(32'h0000_0F00, 16'd20, 1, 3'd2, 1, "R6 ring of 8 word");
    do_adv(9, "R6 ring of 8 wrap");
    do_load(32'h0000_0400, 16'd40, 1, 3'd7, 0, "R6 code 7 clamps");
    do_adv(33, "R6 code 7 acts as 32");
    do_load(32'h0000_0105, 16'd6, 1, 3'd1, 1, "R9 misaligned ring start");
    do_adv(5, "R9 aligned ring of 4 words");
    do_load(32'h0000_0100, 16'd2, 1, 3'd1, 1, "R9 aligned load clears flag");
    do_adv(2, "R10 count to zero");
    do_idle("R10 pulse ends");
    do_adv(3, "R10 advance ignored at zero");
    do_load(32'h0000_5000, 16'd9, 0, 0, 0, "R2 before priority");
    do_adv(2, "R3 step");
    drive(1, 1, 32'h0000_7000, 16'd4, 0, 0, 0, "R11 load beats advance");
    do_idle("R11 hold");
    do_adv(1, "R11 resumes");
    do_idle("R1 end");
    wait (qa.size() == 0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule